// File: doc/BRIEF.md
# Bus Grant Arbiter

This block is the processor-side controller for a three-wire bus hand-over scheme: request, grant and grant-acknowledge. Any number of other devices may ask for the bus by pulling an active-low request line low. These lines are combined as a wired-AND, so a low on any one counts as a request. The block answers with an active-low bus grant. It then waits for the new master to take the bus by asserting the active-low acknowledge, and negates the grant a fixed number of clocks after that. If requests are still pending after the grant falls, the grant is raised again after a second fixed delay. This lets external logic choose the next master while the present one is still using the bus.

The core side needs two signals. The first tells the core when it may start a new bus cycle. The second is an input from the core that shows whether its own cycle is still running. Choosing between several masters is left to external logic. Requests are honoured whatever the processor is doing, including while it is in reset, halted, or stopped after a double bus fault. The request and acknowledge inputs are asynchronous and pass through a two-flop synchroniser. None of the pins is a data stream, so all of them are plain level signals with no back-pressure.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While the block reset `rst_n` is low, and right after it, `bg_n` is 1. `core_start_ok` is then 1 whenever `core_stopped` is 0.
- R2: When a request goes low, `bg_n` goes low on the third rising clock edge after the edge at which the request was first low. It is still 1 after the second edge.
- R3: Any non-empty set of low bits on `req_n` counts as one request, with the same timing as a single low bit.
- R4: A 1-to-0 transition of `ack_n` while the grant is asserted makes `bg_n` return to 1 exactly 3+NEG_DLY edges after `ack_n` was first low. A request released at the same moment does not change this timing.
- R5: If a request is still pending when the grant falls, `bg_n` goes low again exactly REGRANT_DLY edges later, even while `ack_n` is still held low.
- R6: If no request is pending once the re-grant delay has run out, `bg_n` stays 1. After `ack_n` returns high, `core_start_ok` goes back to 1 on the second edge (this requires `core_stopped` to be 0).
- R7: If every request line goes high while the grant is asserted and no new acknowledge edge has arrived, `bg_n` returns to 1 on the third edge.
- R8: `core_stopped`, which marks reset, halt or the double-fault halted state of the processor, has no effect on the timing of `bg_n`.
- R9: `core_start_ok` is 0 while the grant is asserted, while the synchronised acknowledge is asserted, or while `core_stopped` is 1.
- R10: `bus_free_for_master` is 1 only when the grant is asserted, `core_busy` is 0 and the synchronised acknowledge is not asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| req_n | input | REQ_LINES | Bus request lines, active low, combined as a wired-AND |
| ack_n | input | 1 | Grant acknowledge from the new master, active low |
| core_busy | input | 1 | The processor's own bus cycle is still running |
| core_stopped | input | 1 | The processor is in reset, halted or stopped after a double fault |
| bg_n | output | 1 | Bus grant, active low |
| core_start_ok | output | 1 | The core may start a new bus cycle |
| bus_free_for_master | output | 1 | The grant is out and the bus currently has no active master |

## Verification
Some properties are checked by assertions on every cycle:
- the grant rises only after a synchronised request;
- the grant falls only on a withdrawn request or at the end of the negation delay;
- the grant stays off during the re-grant gap;
- `core_start_ok` and `bus_free_for_master` never appear without the grant state they depend on.

The exact edge counts can only be shown by the bench's scenarios. These cover the synchroniser latency, the NEG_DLY and REGRANT_DLY windows, the re-grant while the acknowledge is still held, and the return to the core once the acknowledge is released. The bench repeats them for every request-line pattern, with and without a stopped processor.

// File: rtl/bga_pkg.sv
package bga_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANT   = 2'd1,
    ST_NEGWAIT = 2'd2,
    ST_REGRANT = 2'd3
  } arb_state_e;
endpackage

// File: rtl/bga_sync.sv
module bga_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= '0;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/bga_delay_cnt.sv
module bga_delay_cnt #(
  parameter int unsigned MAXV = 2,
  parameter int unsigned CW   = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bga_fsm.sv
module bga_fsm
  import bga_pkg::*;
#(
  parameter int unsigned NEG_DLY     = 2,
  parameter int unsigned REGRANT_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  output logic grant
);
  localparam int unsigned MAXD   = (NEG_DLY > REGRANT_DLY) ? NEG_DLY : REGRANT_DLY;
  localparam int unsigned CW     = $clog2(MAXD + 1);
  localparam logic [CW-1:0] NEG_LD = CW'(NEG_DLY - 1);
  localparam logic [CW-1:0] RG_LD  = CW'(REGRANT_DLY - 1);

  arb_state_e    state, nxt;
  logic          ack_d;
  logic          ack_rise;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ack_d <= 1'b0;
    end else begin
      state <= nxt;
      ack_d <= ack_s;
    end
  end

  assign ack_rise = ack_s & ~ack_d;

  always_comb begin
    nxt    = state;
    ld     = 1'b0;
    ld_val = '0;
    unique case (state)
      ST_IDLE: begin
        if (req_s) nxt = ST_GRANT;
      end
      ST_GRANT: begin
        if (ack_rise) begin
          nxt    = ST_NEGWAIT;
          ld     = 1'b1;
          ld_val = NEG_LD;
        end else if (!req_s) begin
          nxt = ST_IDLE;
        end
      end
      ST_NEGWAIT: begin
        if (cnt_zero) begin
          nxt    = ST_REGRANT;
          ld     = 1'b1;
          ld_val = RG_LD;
        end
      end
      ST_REGRANT: begin
        if (cnt_zero) nxt = req_s ? ST_GRANT : ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  bga_delay_cnt #(.MAXV(MAXD), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .zero     (cnt_zero)
  );

  assign grant = (state == ST_GRANT) || (state == ST_NEGWAIT);

  // R2
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req_s));

  // R4
  grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant) |-> ($past(!req_s) || $past(state == ST_NEGWAIT)));

  // R5
  regrant_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REGRANT && !cnt_zero) |=> !grant);
endmodule

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int unsigned REQ_LINES   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NEG_DLY     = 2,
  parameter int unsigned REGRANT_DLY = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REQ_LINES-1:0] req_n,
  input  logic                 ack_n,
  input  logic                 core_busy,
  input  logic                 core_stopped,
  output logic                 bg_n,
  output logic                 core_start_ok,
  output logic                 bus_free_for_master
);
  logic       req_any;
  logic [1:0] sync_q;
  logic       req_s;
  logic       ack_s;
  logic       grant;

  // wired-AND of active-low lines: any low line is a request
  assign req_any = ~&req_n;

  bga_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({req_any, ~ack_n}),
    .q     (sync_q)
  );

  assign req_s = sync_q[1];
  assign ack_s = sync_q[0];

  bga_fsm #(.NEG_DLY(NEG_DLY), .REGRANT_DLY(REGRANT_DLY)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .req_s (req_s),
    .ack_s (ack_s),
    .grant (grant)
  );

  assign bg_n                = ~grant;
  assign core_start_ok       = ~grant & ~ack_s & ~core_stopped;
  assign bus_free_for_master = grant & ~core_busy & ~ack_s;

  // R9
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start_ok |-> bg_n);

  // R10
  free_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_for_master |-> (!bg_n && !core_busy));
endmodule

// File: tb/bus_grant_arbiter_tb.sv
module bus_grant_arbiter_tb;
  localparam int unsigned LINES = 3;
  localparam int unsigned NEG   = 2;
  localparam int unsigned RG    = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LINES-1:0] req_n;
  logic             ack_n;
  logic             core_busy;
  logic             core_stopped;
  logic             bg_n;
  logic             core_start_ok;
  logic             bus_free_for_master;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bus_grant_arbiter #(
    .REQ_LINES(LINES), .SYNC_STAGES(2), .NEG_DLY(NEG), .REGRANT_DLY(RG)
  ) u_dut (
    .clk                 (clk),
    .rst_n               (rst_n),
    .req_n               (req_n),
    .ack_n               (ack_n),
    .core_busy           (core_busy),
    .core_stopped        (core_stopped),
    .bg_n                (bg_n),
    .core_start_ok       (core_start_ok),
    .bus_free_for_master (bus_free_for_master)
  );

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_n = '1; ack_n = 1'b1; core_busy = 1'b0; core_stopped = 1'b0;
    nclk(3);
    chk("R1 bg_n in reset", bg_n, 1'b1);
    chk("R1 start_ok in reset", core_start_ok, 1'b1);
    rst_n = 1'b1;
    nclk(1);
    chk("R1 bg_n after reset", bg_n, 1'b1);
    chk("R1 start_ok after reset", core_start_ok, 1'b1);

    // R7: withdrawn request without acknowledge
    req_n = 3'b110;
    nclk(3);
    chk("R7 granted", bg_n, 1'b0);
    req_n = '1;
    nclk(2);
    chk("R7 held before withdraw seen", bg_n, 1'b0);
    nclk(1);
    chk("R7 grant dropped", bg_n, 1'b1);
    nclk(3);

    for (int st = 0; st < 2; st++) begin
      for (int rg = 0; rg < 2; rg++) begin
        for (int p = 1; p < (1 << LINES); p++) begin
          core_stopped = st[0];
          req_n = '1; ack_n = 1'b1; core_busy = 1'b0;
          nclk(4);
          chk($sformatf("R6 idle p=%0d st=%0d", p, st), bg_n, 1'b1);
          chk($sformatf("R9 idle start_ok st=%0d", st), core_start_ok, ~st[0]);

          req_n = ~p[LINES-1:0];
          nclk(2);
          chk($sformatf("R2 not early p=%0d", p), bg_n, 1'b1);
          nclk(1);
          chk($sformatf("R2 R3 R8 grant p=%0d st=%0d", p, st), bg_n, 1'b0);
          chk("R9 blocked by grant", core_start_ok, 1'b0);
          core_busy = 1'b1; #1;
          chk("R10 busy core", bus_free_for_master, 1'b0);
          core_busy = 1'b0; #1;
          chk("R10 free", bus_free_for_master, 1'b1);

          ack_n = 1'b0;
          if (rg == 0) req_n = '1;
          nclk(2 + NEG);
          chk($sformatf("R4 grant held p=%0d rg=%0d", p, rg), bg_n, 1'b0);
          chk("R10 acked", bus_free_for_master, 1'b0);
          nclk(1);
          chk($sformatf("R4 grant negated p=%0d rg=%0d", p, rg), bg_n, 1'b1);
          chk("R9 blocked by ack", core_start_ok, 1'b0);

          if (rg == 1) begin
            nclk(RG - 1);
            chk($sformatf("R5 gap p=%0d", p), bg_n, 1'b1);
            nclk(1);
            chk($sformatf("R5 regrant with ack held p=%0d", p), bg_n, 1'b0);
            ack_n = 1'b1; req_n = '1;
            nclk(2);
            chk("R7 regrant held", bg_n, 1'b0);
            nclk(1);
            chk("R7 regrant withdrawn", bg_n, 1'b1);
          end else begin
            nclk(RG + 3);
            chk($sformatf("R6 no regrant p=%0d", p), bg_n, 1'b1);
            ack_n = 1'b1;
            nclk(1);
            chk("R6 still blocked", core_start_ok, 1'b0);
            nclk(1);
            chk($sformatf("R6 resume st=%0d", st), core_start_ok, ~st[0]);
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule